// File: doc/BRIEF.md
# Rewindable FIFO with Read Mark

A single-clock first-in first-out buffer. The data width is a parameter and the depth is a power of two. The producer stores a word only when both of its enables are high. The consumer likewise needs two enables to take a word. One input takes a snapshot of the read position, and another input rewinds the read position so that already-consumed words can be replayed. The rewind goes to the snapshot if one exists and to the start of storage otherwise. Stored words are never erased by a read, so a replay returns exactly what was written.

The read side has two timing modes, chosen by a select input that is sampled only while master reset is held. In standard mode a read request fetches the head word into the output register, and an active-high empty flag tells the consumer when nothing is left. In look-ahead mode the head word sits in the output register without any request, and an output-ready flag marks it as valid. A read request then only discards it.

A partial reset returns both pointers and the output register to zero and drops any snapshot. It keeps the mode chosen at master reset. While a snapshot is held, the snapshotted region is protected: the full flag counts every word from the snapshot to the write position.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst` is high at a clock edge the block clears both pointers, the snapshot and `rd_data`, and it captures `fwft_sel` as the mode (0 = standard, 1 = look-ahead). After reset `full` is 0. In standard mode `empty` is 1 and `out_rdy` is 0; in look-ahead mode `empty` is 0 and `out_rdy` is 0. Later changes of `fwft_sel` have no effect.
- R2: A word is stored only at an edge where `wr_en` and `wr_cs` are both 1 and `full` is 0. Without a snapshot, `full` is 1 when DEPTH unread words are held. Words offered while `full` is 1 are dropped.
- R3: In standard mode, an edge with `rd_en`=1, `rd_cs`=1 and `empty`=0 places the oldest unread word on `rd_data` after that edge. Words come out in write order. `empty` is 1 whenever no unread word remains.
- R4: In look-ahead mode, the first word written into an empty buffer appears on `rd_data` with `out_rdy`=1 after the write edge, with no read request. An edge with `rd_en`=1, `rd_cs`=1 and `out_rdy`=1 moves to the next word, or drops `out_rdy` if there is none.
- R5: With `rd_cs`=0 a read request is ignored: `rd_data` and the flags stay unchanged.
- R6: An edge with `prst`=1 zeroes both pointers and `rd_data`, drops `out_rdy`, discards the snapshot and keeps the mode.
- R7: An edge with `rt`=1 and no snapshot sets the read position to word 0 and leaves the write position alone. In standard mode `empty` is 1 for the following cycle. Reads then replay from word 0, and read requests at the `rt` edge are ignored.
- R8: In look-ahead mode, `out_rdy` is 0 after an `rt` edge. After the next edge the word at the rewound position is on `rd_data` with `out_rdy`=1, with no read request.
- R9: An edge with `mark`=1 and `rt`=0 records the position of the next word the consumer will receive. A later `rt` rewinds to that position. `mark` is ignored at an edge where `rt` is 1.
- R10: While a snapshot is held, `full` is 1 when DEPTH words lie between the snapshot and the write position, even if fewer are unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous master reset, active high |
| fwft_sel | input | 1 | Mode select sampled during master reset: 0 standard, 1 look-ahead |
| prst | input | 1 | Synchronous partial reset, active high |
| wr_en | input | 1 | Write enable |
| wr_cs | input | 1 | Write chip select, second write enable |
| wr_data | input | DW | Write word |
| rd_en | input | 1 | Read enable |
| rd_cs | input | 1 | Read chip select |
| rt | input | 1 | Retransmit: rewind read position |
| mark | input | 1 | Snapshot the read position |
| rd_data | output | DW | Output register |
| empty | output | 1 | No unread word (standard mode only) |
| out_rdy | output | 1 | `rd_data` holds a valid word (look-ahead mode only) |
| full | output | 1 | Writes are blocked |

## Verification
Plain write-then-read bursts in both modes show that order and latency are right. A run that fills to DEPTH and then offers one more word shows that the overflow word is dropped. Rewinds are applied with no snapshot, with a snapshot, and with `mark` and `rt` pulsed together. The replayed first word tells these three cases apart: word 0, the snapshot word, or word 0 again because the snapshot was refused. A fill against a held snapshot, where full arrives two words before DEPTH unread, separates snapshot-based protection from plain occupancy. Partial reset followed by a single write checks two things at once: the pointer is back at zero, and the look-ahead mode survived.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  // distance from tail to head on a pointer of pw bits (wraps)
  function automatic int unsigned ptr_span(input logic [31:0] head,
                                           input logic [31:0] tail,
                                           input int unsigned pw);
    logic [31:0] mask;
    mask = (32'd1 << pw) - 32'd1;
    return (head - tail) & mask;
  endfunction

endpackage

// File: rtl/rewind_fifo_ram.sv
module rewind_fifo_ram #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rewind_fifo_oreg.sv
module rewind_fifo_oreg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic          bypass,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (clr)       dout <= '0;
    else if (load) dout <= bypass ? wdata : ram_q;
  end
endmodule

// File: rtl/rewind_fifo_ctrl.sv
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic          wr_cs,
  input  logic          rd_en,
  input  logic          rd_cs,
  input  logic          rt,
  input  logic          mark,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          load_en,
  output logic          bypass,
  output logic          clr_out,
  output logic          empty,
  output logic          out_rdy,
  output logic          full
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;
  typedef logic [AW:0] ptr_t;

  rd_mode_e mode_q;
  ptr_t     wptr_q, rptr_q, mark_q;
  logic     mark_vld_q, hold_q, ordy_q;

  // named internal events
  logic        is_fwft, rd_fire, rt_go, mark_go, no_word;
  ptr_t        base, rptr_adv, wptr_nxt, rt_target;
  int unsigned occ_now, occ_base, occ_next;

  always_comb begin
    is_fwft   = (mode_q == RD_FWFT);
    base      = mark_vld_q ? mark_q : rptr_q;
    occ_now   = ptr_span(32'(wptr_q), 32'(rptr_q), PW);
    occ_base  = ptr_span(32'(wptr_q), 32'(base), PW);
    full      = (occ_base == DEPTH);
    no_word   = hold_q || (occ_now == 0);
    empty     = !is_fwft && no_word;
    out_rdy   = is_fwft && ordy_q;
    rt_go     = rt && !prst;
    mark_go   = mark && !rt && !prst;
    wr_fire   = wr_en && wr_cs && !full && !prst;
    rd_fire   = rd_en && rd_cs && !rt && (is_fwft ? ordy_q : !no_word);
    rptr_adv  = rptr_q + {{AW{1'b0}}, rd_fire};
    wptr_nxt  = wptr_q + {{AW{1'b0}}, wr_fire};
    rt_target = mark_vld_q ? mark_q : '0;
    occ_next  = ptr_span(32'(wptr_nxt), 32'(rptr_adv), PW);
    wr_addr   = wptr_q[AW-1:0];
    rd_addr   = is_fwft ? rptr_adv[AW-1:0] : rptr_q[AW-1:0];
    bypass    = is_fwft && wr_fire && (wr_addr == rd_addr);
    load_en   = is_fwft ? (!rt_go && occ_next != 0) : rd_fire;
    clr_out   = rst || prst;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= fwft_sel ? RD_FWFT : RD_STD;
    if (rst || prst) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      mark_q     <= '0;
      mark_vld_q <= 1'b0;
      hold_q     <= 1'b0;
      ordy_q     <= 1'b0;
    end else begin
      wptr_q <= wptr_nxt;
      if (rt_go) begin
        rptr_q <= rt_target;
        hold_q <= 1'b1;
        ordy_q <= 1'b0;
      end else begin
        rptr_q <= rptr_adv;
        hold_q <= 1'b0;
        ordy_q <= is_fwft && (occ_next != 0);
      end
      if (mark_go) begin
        mark_q     <= rptr_q;
        mark_vld_q <= 1'b1;
      end
    end
  end

  // R2 / R10: protected span never exceeds storage
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    occ_base <= DEPTH);
  // R10: read position never falls behind the snapshot
  assert_mark_behind_R10: assert property (@(posedge clk) disable iff (rst)
    mark_vld_q |-> (occ_now <= occ_base));
  assert_rt_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (rt_go && !is_fwft) |=> empty);
  assert_rt_keeps_wptr_R7: assert property (@(posedge clk) disable iff (rst)
    (rt_go && !wr_fire) |=> (wptr_q == $past(wptr_q)));
  assert_rt_ordy_R8: assert property (@(posedge clk) disable iff (rst)
    (rt_go && is_fwft) |=> !out_rdy);
  assert_mode_kept_R6: assert property (@(posedge clk) disable iff (rst)
    prst |=> $stable(mode_q));
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwft_sel,
  input  logic          prst,
  input  logic          wr_en,
  input  logic          wr_cs,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_cs,
  input  logic          rt,
  input  logic          mark,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          out_rdy,
  output logic          full
);
  logic          wr_fire, load_en, bypass, clr_out;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] ram_q;

  rewind_fifo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .prst(prst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_cs(wr_cs), .rd_en(rd_en), .rd_cs(rd_cs),
    .rt(rt), .mark(mark), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .load_en(load_en), .bypass(bypass),
    .clr_out(clr_out), .empty(empty), .out_rdy(out_rdy), .full(full)
  );

  rewind_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(ram_q)
  );

  rewind_fifo_oreg #(.DW(DW)) u_oreg (
    .clk(clk), .clr(clr_out), .load(load_en), .bypass(bypass),
    .ram_q(ram_q), .wdata(wr_data), .dout(rd_data)
  );

  // R6: partial reset empties the output stage
  assert_prst_clear_R6: assert property (@(posedge clk) disable iff (rst)
    prst |=> (rd_data == '0 && !out_rdy && !full));
  // R1: master reset leaves nothing valid and nothing full
  assert_rst_state_R1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !out_rdy && !full));
endmodule

// File: tb/rewind_fifo_tb.sv
module rewind_fifo_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1, fwft_sel = 1'b0, prst = 1'b0;
  logic wr_en = 1'b0, wr_cs = 1'b0, rd_en = 1'b0, rd_cs = 1'b0;
  logic rt = 1'b0, mark = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic empty, out_rdy, full;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rewind_fifo #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .fwft_sel(fwft_sel), .prst(prst),
    .wr_en(wr_en), .wr_cs(wr_cs), .wr_data(wr_data),
    .rd_en(rd_en), .rd_cs(rd_cs), .rt(rt), .mark(mark),
    .rd_data(rd_data), .empty(empty), .out_rdy(out_rdy), .full(full)
  );

  function automatic logic [31:0] dw(input int i);
    return 32'hA000_0000 + 32'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mreset(input logic fw);
    rst = 1'b1; fwft_sel = fw;
    tick(); tick();
    rst = 1'b0; fwft_sel = ~fw;
  endtask

  task automatic push(input logic [31:0] v);
    wr_en = 1'b1; wr_cs = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0; wr_cs = 1'b0;
  endtask

  task automatic pop_std(input logic [31:0] exp, input string req);
    rd_en = 1'b1; rd_cs = 1'b1;
    tick();
    rd_en = 1'b0; rd_cs = 1'b0;
    check(req, rd_data, exp);
  endtask

  task automatic pop_fwft(input logic [31:0] exp, input string req);
    check(req, rd_data, exp);
    check(req, 32'(out_rdy), 32'd1);
    rd_en = 1'b1; rd_cs = 1'b1;
    tick();
    rd_en = 1'b0; rd_cs = 1'b0;
  endtask

  task automatic pulse_rt(input logic with_mark);
    rt = 1'b1; mark = with_mark;
    tick();
    rt = 1'b0; mark = 1'b0;
  endtask

  task automatic t_reset();
    mreset(1'b0);
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 full", 32'(full), 32'd0);
    check("R1 out_rdy", 32'(out_rdy), 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
  endtask

  task automatic t_std_rw();
    mreset(1'b0);
    for (int i = 0; i < 3; i++) push(dw(i));
    check("R3 not empty", 32'(empty), 32'd0);
    for (int i = 0; i < 3; i++) pop_std(dw(i), "R3 order");
    check("R3 empty after drain", 32'(empty), 32'd1);
  endtask

  task automatic t_selects();
    mreset(1'b0);
    wr_en = 1'b1; wr_cs = 1'b0; wr_data = dw(50);
    tick();
    wr_en = 1'b0;
    check("R2 wr_cs low blocks write", 32'(empty), 32'd1);
    push(dw(51));
    pop_std(dw(51), "R2 write lands");
    push(dw(52));
    rd_en = 1'b1; rd_cs = 1'b0;
    tick();
    rd_en = 1'b0;
    check("R5 rd_cs low data kept", rd_data, dw(51));
    check("R5 rd_cs low empty kept", 32'(empty), 32'd0);
    pop_std(dw(52), "R5 word still there");
  endtask

  task automatic t_full();
    mreset(1'b0);
    for (int i = 0; i < DEPTH; i++) push(dw(i));
    check("R2 full at depth", 32'(full), 32'd1);
    push(dw(99));
    for (int i = 0; i < DEPTH; i++) pop_std(dw(i), "R2 order after fill");
    check("R2 overflow word dropped", 32'(empty), 32'd1);
  endtask

  task automatic t_rt_std();
    mreset(1'b0);
    for (int i = 0; i < 4; i++) push(dw(i));
    pop_std(dw(0), "R7 pre");
    pop_std(dw(1), "R7 pre");
    pulse_rt(1'b0);
    check("R7 empty after rewind", 32'(empty), 32'd1);
    tick();
    check("R7 empty clears", 32'(empty), 32'd0);
    for (int i = 0; i < 4; i++) pop_std(dw(i), "R7 replay");
    check("R7 write pointer kept", 32'(empty), 32'd1);
  endtask

  task automatic t_mark_std();
    mreset(1'b0);
    for (int i = 0; i < 6; i++) push(dw(i));
    pop_std(dw(0), "R9 pre");
    pop_std(dw(1), "R9 pre");
    mark = 1'b1; tick(); mark = 1'b0;
    pop_std(dw(2), "R9 pre");
    pop_std(dw(3), "R9 pre");
    pulse_rt(1'b0);
    tick();
    pop_std(dw(2), "R9 rewind to mark");
  endtask

  task automatic t_mark_ignored();
    mreset(1'b0);
    for (int i = 0; i < 4; i++) push(dw(i));
    pop_std(dw(0), "R9 pre");
    pulse_rt(1'b1);
    tick();
    for (int i = 0; i < 3; i++) pop_std(dw(i), "R9 replay");
    pulse_rt(1'b0);
    tick();
    pop_std(dw(0), "R9 mark with rt ignored");
  endtask

  task automatic t_mark_full();
    mreset(1'b0);
    for (int i = 0; i < 4; i++) push(dw(i));
    pop_std(dw(0), "R10 pre");
    pop_std(dw(1), "R10 pre");
    mark = 1'b1; tick(); mark = 1'b0;
    pop_std(dw(2), "R10 pre");
    pop_std(dw(3), "R10 pre");
    for (int i = 4; i < 17; i++) push(dw(i));
    check("R10 not yet full", 32'(full), 32'd0);
    push(dw(17));
    check("R10 full from mark", 32'(full), 32'd1);
    push(dw(99));
    pulse_rt(1'b0);
    tick();
    for (int i = 2; i < 18; i++) pop_std(dw(i), "R10 protected replay");
    check("R10 overflow dropped", 32'(empty), 32'd1);
  endtask

  task automatic t_fwft();
    mreset(1'b1);
    check("R1 fwft out_rdy", 32'(out_rdy), 32'd0);
    check("R1 fwft empty low", 32'(empty), 32'd0);
    push(dw(0));
    check("R4 first word shown", rd_data, dw(0));
    check("R4 out_rdy up", 32'(out_rdy), 32'd1);
    push(dw(1));
    push(dw(2));
    for (int i = 0; i < 3; i++) pop_fwft(dw(i), "R4 look-ahead order");
    check("R4 out_rdy drops", 32'(out_rdy), 32'd0);
  endtask

  task automatic t_rt_fwft();
    mreset(1'b1);
    for (int i = 0; i < 3; i++) push(dw(i));
    pop_fwft(dw(0), "R8 pre");
    pop_fwft(dw(1), "R8 pre");
    pulse_rt(1'b0);
    check("R8 out_rdy low after rewind", 32'(out_rdy), 32'd0);
    tick();
    check("R8 out_rdy back", 32'(out_rdy), 32'd1);
    pop_fwft(dw(0), "R8 rewound word");
    pop_fwft(dw(1), "R8 next word");
  endtask

  task automatic t_prst();
    mreset(1'b1);
    push(dw(0));
    push(dw(1));
    prst = 1'b1; tick(); prst = 1'b0;
    check("R6 rd_data cleared", rd_data, 32'd0);
    check("R6 out_rdy cleared", 32'(out_rdy), 32'd0);
    push(dw(5));
    check("R6 mode kept", 32'(out_rdy), 32'd1);
    check("R6 pointer zeroed", rd_data, dw(5));
    mreset(1'b0);
    for (int i = 0; i < 3; i++) push(dw(i));
    mark = 1'b1; tick(); mark = 1'b0;
    prst = 1'b1; tick(); prst = 1'b0;
    check("R6 std empty", 32'(empty), 32'd1);
    push(dw(7));
    pop_std(dw(7), "R6 std after partial reset");
  endtask

  initial begin
    tick();
    t_reset();
    t_std_rw();
    t_selects();
    t_full();
    t_rt_std();
    t_mark_std();
    t_mark_ignored();
    t_mark_full();
    t_fwft();
    t_rt_fwft();
    t_prst();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule